// File: doc/BRIEF.md
# Bit-Serial Differential Weight MAC

This block is the digital edge of a resistive crossbar that performs a vector-matrix multiply. A command loads one unsigned activation per word line. The block then sends the activations to the array one bit plane at a time, most significant plane first. Each plane occupies exactly one clock cycle. For each plane the array returns one unsigned conversion code per column. Columns are grouped in pairs, and the two cells of a pair hold a signed weight digit as a conductance difference. A full signed weight is spread over several such pairs. Each pair holds one base-16 digit of the weight, because each cell has 16 levels.

Within a step the block subtracts the negative column of each pair from its positive column. It scales each difference by its digit's power of 16 using a left shift of 4 bits per digit, and sums the digits of one output. It then folds that sum into a per-output accumulator by doubling the accumulator and adding the sum. After the last plane, a one-cycle done pulse marks the finished signed results. The results stay held until the next command is accepted.

The control is a three-state machine. IDLE goes to STEP when start is high. STEP stays in STEP until the last bit plane has been applied. STEP goes to DONE after that last plane. DONE always returns to IDLE on the next cycle.

Top module: `bsd_mac`

## Requirements
- R1: While reset is active and after it is released with no start, wl_out is 0, done is 0 and every result field is 0.
- R2: A start seen in IDLE samples act_in. The block then spends exactly IN_W consecutive step cycles driving the array, beginning in the cycle after the start.
- R3: In step cycle k (k = 0 for the first step), wl_out bit r equals bit IN_W-1-k of activation r. Activation r is act_in[r*IN_W +: IN_W]. Bit planes therefore run from MSB to LSB.
- R4: wl_out is all zero in every cycle that is not a step cycle.
- R5: Column c occupies col_code[c*ADC_W +: ADC_W] and is an unsigned code. For output o, digit s and polarity p (0 = positive, 1 = negative), c = (o*SLICES + s)*2 + p. Each digit contributes the positive code minus the negative code.
- R6: The difference of digit s is weighted by 16^s, that is, shifted left by CELL_BITS*s. Digit 0 is the least significant digit.
- R7: Result o, found at result[o*ACC_W +: ACC_W], equals the sum over rows of activation times signed weight. Each row's signed weight is the sum over digits of 16^s times (positive level minus negative level). The result is in two's complement.
- R8: done is high for exactly one cycle, the cycle after the last step cycle, and the results are final in that cycle.
- R9: A start that arrives during step cycles is ignored. The run in progress completes with its original activations and its timing unchanged.
- R10: Between the done cycle and the next accepted start, results stay constant even when act_in and col_code change.
- R11: Results are taken modulo 2^ACC_W. A true sum outside the ACC_W range wraps and does not saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply when the block is idle |
| act_in | input | N_ROWS*IN_W | Unsigned activations, one per word line |
| col_code | input | N_COLS*ADC_W | Sensed column codes for the current bit plane |
| wl_out | output | N_ROWS | Word-line bit plane driven to the array |
| done | output | 1 | One-cycle pulse: results are final |
| result | output | N_OUT*ACC_W | Signed accumulated results, one per output |

## Verification
The bench targets the order of the bit planes, the polarity and digit placement of the columns, wraparound of the accumulator, and commands issued while a run is busy. Bit planes sent LSB first would show up as a word-line mismatch at step 0. A swapped pair or a misplaced digit would flip the sign of a result or scale it by 16, and weight patterns that drive only one digit or one polarity isolate each of these faults. Driving every cell to its full level with all-ones activations pushes the true sum past 16 bits, so saturating logic or a wider result would disagree with the modulo value. A start pulsed in the middle of a run with different activations would corrupt the results or restart the sequence if it were not ignored, and hold checks after done catch results that drift with the inputs while idle.

// File: rtl/bsd_mac_pkg.sv
package bsd_mac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_DONE = 2'd2
    } mac_state_t;

endpackage

// File: rtl/bsd_mac_slicer.sv
module bsd_mac_slicer #(
    parameter int N_ROWS = 8,
    parameter int IN_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   shift,
    input  logic [N_ROWS*IN_W-1:0] act_in,
    output logic [N_ROWS-1:0]      wl_bits
);

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        logic [IN_W-1:0] sh_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else if (load) begin
                sh_q <= act_in[r*IN_W +: IN_W];
            end else if (shift) begin
                sh_q <= sh_q << 1;
            end
        end

        assign wl_bits[r] = sh_q[IN_W-1];
    end

endmodule

// File: rtl/bsd_mac_combine.sv
module bsd_mac_combine #(
    parameter int N_OUT     = 4,
    parameter int SLICES    = 2,
    parameter int ADC_W     = 8,
    parameter int CELL_BITS = 4,
    parameter int ACC_W     = 16,
    localparam int N_COLS   = N_OUT * SLICES * 2
) (
    input  logic [N_COLS*ADC_W-1:0] col_code,
    output logic [N_OUT*ACC_W-1:0]  wsum
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [ACC_W-1:0] term [SLICES];
        logic [ACC_W-1:0] tot;

        for (genvar s = 0; s < SLICES; s++) begin : g_slice
            localparam int CP = (o*SLICES + s)*2;
            localparam int CN = CP + 1;
            logic [ACC_W-1:0] pos_e, neg_e, diff;

            assign pos_e   = ACC_W'(col_code[CP*ADC_W +: ADC_W]);
            assign neg_e   = ACC_W'(col_code[CN*ADC_W +: ADC_W]);
            assign diff    = pos_e - neg_e;
            assign term[s] = diff << (s*CELL_BITS);
        end

        always_comb begin
            tot = '0;
            for (int s = 0; s < SLICES; s++) begin
                tot = tot + term[s];
            end
        end

        assign wsum[o*ACC_W +: ACC_W] = tot;
    end

endmodule

// File: rtl/bsd_mac_accum.sv
module bsd_mac_accum #(
    parameter int N_OUT = 4,
    parameter int ACC_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   step,
    input  logic [N_OUT*ACC_W-1:0] wsum,
    output logic [N_OUT*ACC_W-1:0] acc
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_acc
        logic [ACC_W-1:0] acc_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (clear) begin
                acc_q <= '0;
            end else if (step) begin
                acc_q <= (acc_q << 1) + wsum[o*ACC_W +: ACC_W];
            end
        end

        assign acc[o*ACC_W +: ACC_W] = acc_q;
    end

endmodule

// File: rtl/bsd_mac.sv
module bsd_mac
    import bsd_mac_pkg::*;
#(
    parameter int N_ROWS    = 8,
    parameter int IN_W      = 8,
    parameter int ADC_W     = 8,
    parameter int CELL_BITS = 4,
    parameter int SLICES    = 2,
    parameter int N_COLS    = 16,
    parameter int ACC_W     = 16,
    localparam int N_OUT    = N_COLS / (2*SLICES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_ROWS*IN_W-1:0]  act_in,
    input  logic [N_COLS*ADC_W-1:0] col_code,
    output logic [N_ROWS-1:0]       wl_out,
    output logic                    done,
    output logic [N_OUT*ACC_W-1:0]  result
);

    localparam int CNT_W = (IN_W > 1) ? $clog2(IN_W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(IN_W - 1);

    mac_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             load, stepping;
    logic [N_ROWS-1:0] wl_bits;
    logic [N_OUT*ACC_W-1:0] wsum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        stepping = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_STEP;
                end
            end
            ST_STEP: begin
                stepping = 1'b1;
                if (cnt_q == LAST_STEP) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (stepping) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    bsd_mac_slicer #(
        .N_ROWS (N_ROWS),
        .IN_W   (IN_W)
    ) u_slicer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (stepping),
        .act_in  (act_in),
        .wl_bits (wl_bits)
    );

    assign wl_out = stepping ? wl_bits : '0;

    bsd_mac_combine #(
        .N_OUT     (N_OUT),
        .SLICES    (SLICES),
        .ADC_W     (ADC_W),
        .CELL_BITS (CELL_BITS),
        .ACC_W     (ACC_W)
    ) u_combine (
        .col_code (col_code),
        .wsum     (wsum)
    );

    bsd_mac_accum #(
        .N_OUT (N_OUT),
        .ACC_W (ACC_W)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .step  (stepping),
        .wsum  (wsum),
        .acc   (result)
    );

endmodule

// File: rtl/bsd_mac_checker.sv
module bsd_mac_checker
    import bsd_mac_pkg::*;
#(
    parameter int N_ROWS = 8,
    parameter int IN_W   = 8,
    parameter int N_OUT  = 4,
    parameter int ACC_W  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input mac_state_t             state,
    input logic [N_ROWS-1:0]      wl_out,
    input logic                   done,
    input logic [N_OUT*ACC_W-1:0] result
);

    int unsigned run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= 0;
        end else if (state == ST_IDLE) begin
            run_cnt <= 0;
        end else if (state == ST_STEP) begin
            run_cnt <= run_cnt + 1;
        end
    end

    a_r2_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == IN_W));

    a_r4_wl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STEP) |-> (wl_out == '0));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP && start && run_cnt < IN_W - 1) |=> (state == ST_STEP));

    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE || (state == ST_IDLE && !start)) |=> $stable(result));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!done && wl_out == '0));

endmodule

bind bsd_mac bsd_mac_checker #(
    .N_ROWS (N_ROWS),
    .IN_W   (IN_W),
    .N_OUT  (N_OUT),
    .ACC_W  (ACC_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .state  (state_q),
    .wl_out (wl_out),
    .done   (done),
    .result (result)
);

// File: tb/bsd_mac_bench.sv
module bsd_mac_bench;

    localparam int N_ROWS = 8;
    localparam int IN_W   = 8;
    localparam int ADC_W  = 8;
    localparam int CELL_BITS = 4;
    localparam int SLICES = 2;
    localparam int N_COLS = 16;
    localparam int ACC_W  = 16;
    localparam int N_OUT  = N_COLS / (2*SLICES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N_ROWS*IN_W-1:0]  act_in = '0;
    logic [N_COLS*ADC_W-1:0] col_code;
    logic [N_ROWS-1:0]       wl_out;
    logic                    done;
    logic [N_OUT*ACC_W-1:0]  result;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int g [N_ROWS][N_COLS];

    always #10 clk = ~clk;

    bsd_mac u_bsd_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .act_in   (act_in),
        .col_code (col_code),
        .wl_out   (wl_out),
        .done     (done),
        .result   (result)
    );

    function automatic int col(int o, int s, int p);
        return (o*SLICES + s)*2 + p;
    endfunction

    function automatic logic [ADC_W-1:0] col_val(int c, logic [N_ROWS-1:0] wl);
        int sum = 0;
        for (int r = 0; r < N_ROWS; r++) begin
            if (wl[r]) sum += g[r][c];
        end
        return ADC_W'(sum);
    endfunction

    always_comb begin
        for (int c = 0; c < N_COLS; c++) begin
            col_code[c*ADC_W +: ADC_W] = col_val(c, wl_out);
        end
    end

    function automatic logic [ACC_W-1:0] exp_out(int o, logic [IN_W-1:0] a [N_ROWS]);
        int tot = 0;
        for (int r = 0; r < N_ROWS; r++) begin
            int w = 0;
            for (int s = 0; s < SLICES; s++) begin
                w += (g[r][col(o,s,0)] - g[r][col(o,s,1)]) * (1 << (CELL_BITS*s));
            end
            tot += int'(a[r]) * w;
        end
        return ACC_W'(tot);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [IN_W-1:0] a [N_ROWS], input bit poke_busy);
        logic [N_OUT*ACC_W-1:0] held;
        for (int r = 0; r < N_ROWS; r++) act_in[r*IN_W +: IN_W] = a[r];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < IN_W; k++) begin
            logic [N_ROWS-1:0] ew;
            for (int r = 0; r < N_ROWS; r++) ew[r] = a[r][IN_W-1-k];
            chk("R3 wl plane", 64'(wl_out), 64'(ew));
            chk("R8 done low in step", 64'(done), 64'd0);
            if (poke_busy && k == 3) begin
                act_in = ~act_in;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R8 done pulse", 64'(done), 64'd1);
        for (int o = 0; o < N_OUT; o++) begin
            chk("R7 result", 64'(result[o*ACC_W +: ACC_W]), 64'(exp_out(o, a)));
        end
        held = result;
        act_in = ~act_in;
        @(negedge clk);
        chk("R8 done single", 64'(done), 64'd0);
        chk("R4 wl idle", 64'(wl_out), 64'd0);
        @(negedge clk);
        chk("R10 result hold", 64'(result), 64'(held));
    endtask

    task automatic set_g(input int mode);
        for (int r = 0; r < N_ROWS; r++) begin
            for (int c = 0; c < N_COLS; c++) begin
                case (mode)
                    0: g[r][c] = int'($urandom_range(15));
                    1: g[r][c] = (c % 2 == 0) ? 15 : 0;
                    2: g[r][c] = (c % 2 == 1) ? 15 : 0;
                    3: g[r][c] = (((c/2) % SLICES) == 1 && c % 2 == 0) ? r + 1 : 0;
                    default: g[r][c] = (((c/2) % SLICES) == 0 && c % 2 == 1) ? r + 2 : 0;
                endcase
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [IN_W-1:0] a [N_ROWS];
        set_g(0);
        repeat (2) @(negedge clk);
        chk("R1 wl in reset", 64'(wl_out), 64'd0);
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 result in reset", 64'(result), 64'd0);
        rst_n = 1'b1;
        act_in = '1;
        repeat (3) @(negedge clk);
        chk("R1 idle wl", 64'(wl_out), 64'd0);
        chk("R1 idle result", 64'(result), 64'd0);

        // R2 R5 R7: random levels and activations
        for (int t = 0; t < 4; t++) begin
            set_g(0);
            for (int r = 0; r < N_ROWS; r++) a[r] = IN_W'($urandom);
            run_op(a, 0);
        end
        // R3: one-hot and alternating planes
        for (int r = 0; r < N_ROWS; r++) a[r] = IN_W'(1 << r);
        run_op(a, 0);
        for (int r = 0; r < N_ROWS; r++) a[r] = (r % 2 == 0) ? 8'hA5 : 8'h5A;
        run_op(a, 0);
        // zero activations
        for (int r = 0; r < N_ROWS; r++) a[r] = '0;
        run_op(a, 0);
        // R5 R11: full positive and full negative with wrap
        for (int r = 0; r < N_ROWS; r++) a[r] = '1;
        set_g(1);
        run_op(a, 0);
        set_g(2);
        run_op(a, 0);
        // R6: upper digit positive only, lower digit negative only
        for (int r = 0; r < N_ROWS; r++) a[r] = IN_W'(3*r + 7);
        set_g(3);
        run_op(a, 0);
        set_g(4);
        run_op(a, 0);
        // R9: start during run ignored
        set_g(0);
        for (int r = 0; r < N_ROWS; r++) a[r] = IN_W'($urandom);
        run_op(a, 1);
        // R10: idle with changing inputs, no start
        begin
            logic [N_OUT*ACC_W-1:0] h;
            h = result;
            for (int t = 0; t < 5; t++) begin
                act_in = {N_ROWS{8'($urandom)}};
                set_g(0);
                @(negedge clk);
                chk("R10 idle hold", 64'(result), 64'(h));
                chk("R4 idle wl zero", 64'(wl_out), 64'd0);
            end
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule